// File: doc/BRIEF.md
# Private Peripheral Region Decoder

This block sits between a core's load/store path and the small register blocks that live in the 1 MB private peripheral region. The 20-bit offset of each request within that region is decoded against several windows that overlap. The request goes to exactly one downstream register block: the system control block, the non-secure timer, the secure timer or the error-reporting block. If no block claims the offset, a built-in default responder answers. Where windows overlap, the narrower timer window wins over the system control page, and any mapped block wins over the default responder.

When the security extension is built in (`SEC_EN=1`), a second page acts as a non-secure view of the system control page and the timer window. A secure request to that page reaches the matching main block with its secure attribute cleared. A non-secure request to that page gets the default answer. The same happens for every request to that page when the extension is absent. The error-reporting block exists only when `ERR_EN=1`.

The downstream blocks answer in the cycle of the request. The decoder registers the chosen read data and fault flag, so the response appears one cycle after the request.

Top module: `ppb_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `rsp_valid`, `rsp_fault` and `rsp_rdata` are all zero.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The response carries the result of that request.
- R3: A request whose offset has page (bits 19:12) 0x0E and low 12 bits below 0x010 or at least 0x0F0 selects `dn_sel[0]`, the system control block.
- R4: A page 0x0E request with low bits in [0x010, 0x0F0) goes to the timer and never to the system control block. With `SEC_EN=1` a secure request selects `dn_sel[2]` and a non-secure one selects `dn_sel[1]`. With `SEC_EN=0` it always selects `dn_sel[1]`.
- R5: With `SEC_EN=1`, a secure request to page 0x2E is forwarded with `dn_secure` low. It selects `dn_sel[1]` for low bits in [0x010, 0x0F0) and `dn_sel[0]` otherwise.
- R6: A non-secure request to page 0x2E, or any request to page 0x2E when `SEC_EN=0`, selects no block and gets the default answer.
- R7: With `ERR_EN=1`, page 0x05 selects `dn_sel[3]`. With `ERR_EN=0` that page gets the default answer.
- R8: When no block is selected, a privileged request (`req_user` low) gets `rsp_fault` low and `rsp_rdata` zero, and a write is dropped. An unprivileged request gets `rsp_fault` high.
- R9: At most one bit of `dn_sel` is high, and none is high while `req_valid` is low.
- R10: For a selected block, `rsp_fault` is that block's `up_fault` bit. `rsp_rdata` is its `up_rdata` slice on reads and zero on writes. Non-alias requests forward `req_secure` unchanged on `dn_secure`.
- R11: All four size codes (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: 8 bytes) are accepted by the default responder. `dn_size`, `dn_write`, `dn_wdata`, `dn_user` and `dn_off` (offset bits 11:0) are forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 20 | Offset within the 1 MB region |
| req_size | input | 2 | Access size code, 1/2/4/8 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_user | input | 1 | Unprivileged request |
| req_secure | input | 1 | Secure request |
| dn_sel | output | 4 | One-hot block select: control, timer NS, timer S, error |
| dn_off | output | 12 | Offset inside the selected 4 KB page |
| dn_size | output | 2 | Forwarded size code |
| dn_write | output | 1 | Forwarded direction |
| dn_wdata | output | DW | Forwarded write data |
| dn_user | output | 1 | Forwarded privilege attribute |
| dn_secure | output | 1 | Security attribute as seen by the block |
| up_rdata | input | 4*DW | Read data of each block, block 0 in the low slice |
| up_fault | input | 4 | Fault flag of each block |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW | Response read data |
| rsp_fault | output | 1 | Response fault |

## Verification
The assertions assume that `req_valid` stays low while reset is asserted. They also assume that the downstream blocks return `up_rdata` and `up_fault` combinationally in the cycle they are selected, so the registered response reflects that cycle. The stimulus changes inputs only on falling edges and holds `req_valid` low through reset. It models every block as a combinational function of `dn_off` and a per-request fault mask, and it sweeps all 256 pages over boundary offsets, both attributes, both directions and every size code.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int OFF_W   = 20;
  localparam int PG_OFF_W = 12;
  localparam int N_SLV   = 4;

  localparam int SLV_CTRL  = 0;
  localparam int SLV_TMR_N = 1;
  localparam int SLV_TMR_S = 2;
  localparam int SLV_ERR   = 3;

  localparam logic [7:0]  PAGE_CTRL  = 8'h0E;
  localparam logic [7:0]  PAGE_ALIAS = 8'h2E;
  localparam logic [7:0]  PAGE_ERR   = 8'h05;
  localparam logic [12:0] TMR_LO     = 13'h010;
  localparam logic [12:0] TMR_HI     = 13'h0F0;
  localparam logic [12:0] PAGE_END   = 13'h1000;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ppb_window.sv
module ppb_window
  import ppb_pkg::*;
#(
  parameter logic [7:0]  PAGE = 8'h00,
  parameter logic [12:0] LO   = 13'h000,
  parameter logic [12:0] HI   = 13'h1000
) (
  input  logic [OFF_W-1:0] off,
  output logic             hit
);
  localparam bit WHOLE_PAGE = (LO == 13'h000) && (HI == PAGE_END);

  logic page_eq;
  assign page_eq = (off[OFF_W-1:PG_OFF_W] == PAGE);

  generate
    if (WHOLE_PAGE) begin : g_page
      assign hit = page_eq;
    end else begin : g_range
      logic [12:0] lo_ext;
      assign lo_ext = {1'b0, off[PG_OFF_W-1:0]};
      assign hit = page_eq && (lo_ext >= LO) && (lo_ext < HI);
    end
  endgenerate
endmodule

// File: rtl/ppb_route.sv
module ppb_route
  import ppb_pkg::*;
#(
  parameter bit SEC_EN = 1'b1,
  parameter bit ERR_EN = 1'b1
) (
  input  logic             req_valid,
  input  logic [OFF_W-1:0] off,
  input  logic             req_secure,
  output logic [N_SLV-1:0] sel,
  output logic             fwd_secure,
  output logic             is_dflt
);
  logic ctrl_hit, tmr_hit, als_hit, als_tmr_hit, err_hit;

  ppb_window #(.PAGE(PAGE_CTRL), .LO(13'h000), .HI(PAGE_END)) u_win_ctrl (
    .off(off), .hit(ctrl_hit));
  ppb_window #(.PAGE(PAGE_CTRL), .LO(TMR_LO), .HI(TMR_HI)) u_win_tmr (
    .off(off), .hit(tmr_hit));
  ppb_window #(.PAGE(PAGE_ALIAS), .LO(13'h000), .HI(PAGE_END)) u_win_als (
    .off(off), .hit(als_hit));
  ppb_window #(.PAGE(PAGE_ALIAS), .LO(TMR_LO), .HI(TMR_HI)) u_win_als_tmr (
    .off(off), .hit(als_tmr_hit));

  generate
    if (ERR_EN) begin : g_err
      ppb_window #(.PAGE(PAGE_ERR), .LO(13'h000), .HI(PAGE_END)) u_win_err (
        .off(off), .hit(err_hit));
    end else begin : g_no_err
      assign err_hit = 1'b0;
    end
  endgenerate

  logic sec_view;
  assign sec_view = SEC_EN && req_secure;

  // Priority: alias page, timer window, control page, error page, default.
  always_comb begin
    sel = '0;
    if (req_valid) begin
      if (als_hit) begin
        if (sec_view) begin
          if (als_tmr_hit) sel[SLV_TMR_N] = 1'b1;
          else             sel[SLV_CTRL]  = 1'b1;
        end
      end else if (tmr_hit) begin
        if (sec_view) sel[SLV_TMR_S] = 1'b1;
        else          sel[SLV_TMR_N] = 1'b1;
      end else if (ctrl_hit) begin
        sel[SLV_CTRL] = 1'b1;
      end else if (err_hit) begin
        sel[SLV_ERR] = 1'b1;
      end
    end
  end

  assign fwd_secure = req_secure & ~als_hit;
  assign is_dflt    = ~|sel;
endmodule

// File: rtl/ppb_decoder.sv
module ppb_decoder
  import ppb_pkg::*;
#(
  parameter int DW     = 32,
  parameter bit SEC_EN = 1'b1,
  parameter bit ERR_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [19:0]         req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic [DW-1:0]       req_wdata,
  input  logic                req_user,
  input  logic                req_secure,
  output logic [3:0]          dn_sel,
  output logic [11:0]         dn_off,
  output logic [1:0]          dn_size,
  output logic                dn_write,
  output logic [DW-1:0]       dn_wdata,
  output logic                dn_user,
  output logic                dn_secure,
  input  logic [4*DW-1:0]     up_rdata,
  input  logic [3:0]          up_fault,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_fault
);
  logic is_dflt;

  ppb_route #(.SEC_EN(SEC_EN), .ERR_EN(ERR_EN)) u_route (
    .req_valid (req_valid),
    .off       (req_addr),
    .req_secure(req_secure),
    .sel       (dn_sel),
    .fwd_secure(dn_secure),
    .is_dflt   (is_dflt)
  );

  assign dn_off   = req_addr[PG_OFF_W-1:0];
  assign dn_size  = req_size;
  assign dn_write = req_write;
  assign dn_wdata = req_wdata;
  assign dn_user  = req_user;

  // Select the answering block's read data and fault.
  logic [DW-1:0] slv_rdata [N_SLV];
  logic [N_SLV-1:0] slv_fault;
  genvar gi;
  generate
    for (gi = 0; gi < N_SLV; gi++) begin : g_mux
      assign slv_rdata[gi] = dn_sel[gi] ? up_rdata[gi*DW +: DW] : '0;
      assign slv_fault[gi] = dn_sel[gi] & up_fault[gi];
    end
  endgenerate

  logic [DW-1:0] mux_rdata;
  always_comb begin
    mux_rdata = '0;
    for (int i = 0; i < N_SLV; i++) mux_rdata = mux_rdata | slv_rdata[i];
  end

  logic          rsp_valid_d, rsp_fault_d, rsp_ce;
  logic [DW-1:0] rsp_rdata_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_fault_d = 1'b0;
    rsp_rdata_d = '0;
    if (req_valid) begin
      if (is_dflt) begin
        rsp_fault_d = req_user;
      end else begin
        rsp_fault_d = |slv_fault;
        if (!req_write) rsp_rdata_d = mux_rdata;
      end
    end
  end

  assign rsp_ce = req_valid | rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else if (rsp_ce) begin
      rsp_valid <= rsp_valid_d;
      rsp_fault <= rsp_fault_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  // Checks on the routing and the response pipeline.
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_sel));
  assert_idle_nosel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (dn_sel == '0));
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_tmr_sec_steer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sel[SLV_TMR_S] |-> req_secure);
  assert_alias_downgrade_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[19:12] == PAGE_ALIAS) && (|dn_sel)) |-> !dn_secure);
  assert_dflt_user_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (dn_sel == '0) && req_user) |=> rsp_fault);
  assert_dflt_priv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (dn_sel == '0) && !req_user) |=> (!rsp_fault && (rsp_rdata == '0)));

  generate
    if (!SEC_EN) begin : g_chk_nosec
      assert_no_sec_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_sel[SLV_TMR_S]);
      assert_alias_dflt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[19:12] == PAGE_ALIAS) |-> (dn_sel == '0));
    end
    if (!ERR_EN) begin : g_chk_noerr
      assert_no_err_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_sel[SLV_ERR]);
    end
  endgenerate
endmodule

// File: tb/ppb_decoder_bench.sv
`timescale 1ns/1ps
module ppb_decoder_bench;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic [19:0]   req_addr;
  logic [1:0]    req_size;
  logic          req_write;
  logic [DW-1:0] req_wdata;
  logic          req_user;
  logic          req_secure;
  logic [3:0]    fmask;

  // Full configuration.
  logic [3:0] a_sel; logic [11:0] a_off; logic [1:0] a_size;
  logic a_write, a_user, a_secure, a_rv, a_rf;
  logic [DW-1:0] a_wdata, a_rd;
  logic [4*DW-1:0] a_up;
  // Reduced configuration: no security extension, no error block.
  logic [3:0] b_sel; logic [11:0] b_off; logic [1:0] b_size;
  logic b_write, b_user, b_secure, b_rv, b_rf;
  logic [DW-1:0] b_wdata, b_rd;
  logic [4*DW-1:0] b_up;

  function automatic logic [DW-1:0] slv_word(input int idx, input logic [11:0] off);
    return {8'hA0 | 8'(idx), 12'h000, off};
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      a_up[i*DW +: DW] = slv_word(i, a_off);
      b_up[i*DW +: DW] = slv_word(i, b_off);
    end
  end

  ppb_decoder #(.DW(DW), .SEC_EN(1'b1), .ERR_EN(1'b1)) u_ppb_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_user(req_user), .req_secure(req_secure),
    .dn_sel(a_sel), .dn_off(a_off), .dn_size(a_size), .dn_write(a_write),
    .dn_wdata(a_wdata), .dn_user(a_user), .dn_secure(a_secure),
    .up_rdata(a_up), .up_fault(fmask),
    .rsp_valid(a_rv), .rsp_rdata(a_rd), .rsp_fault(a_rf));

  ppb_decoder #(.DW(DW), .SEC_EN(1'b0), .ERR_EN(1'b0)) u_ppb_decoder_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_user(req_user), .req_secure(req_secure),
    .dn_sel(b_sel), .dn_off(b_off), .dn_size(b_size), .dn_write(b_write),
    .dn_wdata(b_wdata), .dn_user(b_user), .dn_secure(b_secure),
    .up_rdata(b_up), .up_fault(fmask),
    .rsp_valid(b_rv), .rsp_rdata(b_rd), .rsp_fault(b_rf));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected target: 0..3 block index, -1 default answer.
  function automatic int exp_tgt(input logic [19:0] a, input bit sec,
                                 input bit sec_en, input bit err_en);
    logic [7:0] pg = a[19:12];
    logic [11:0] lo = a[11:0];
    bit in_tmr = (lo >= 12'h010) && (lo < 12'h0F0);
    if (pg == 8'h2E) return (sec_en && sec) ? (in_tmr ? 1 : 0) : -1;
    if (pg == 8'h0E) begin
      if (in_tmr) return (sec_en && sec) ? 2 : 1;
      return 0;
    end
    if (pg == 8'h05 && err_en) return 3;
    return -1;
  endfunction

  function automatic string tag_of(input logic [7:0] pg, input int t, input bit sec_en);
    if (t < 0) return (pg == 8'h2E) ? "R6" : ((pg == 8'h05) ? "R7" : "R8");
    if (pg == 8'h2E) return "R5";
    if (t == 3) return "R7";
    if (t == 0) return "R3";
    return sec_en ? "R4" : "R4";
  endfunction

  task automatic check_sel(input bit lite, input int t, input logic [3:0] sel,
                           input logic sec_o, input logic [11:0] off_o, input logic [1:0] sz_o,
                           input logic wr_o, input logic [DW-1:0] wd_o, input logic us_o);
    logic [3:0] exp_sel = (t < 0) ? 4'b0 : 4'(1 << t);
    string tg = tag_of(req_addr[19:12], t, !lite);
    chk(sel == exp_sel, tg, lite ? "lite sel" : "sel", 64'(sel), 64'(exp_sel));
    if (t >= 0) begin
      logic exp_sec = (req_addr[19:12] == 8'h2E) ? 1'b0 : req_secure;
      chk(sec_o == exp_sec, (req_addr[19:12] == 8'h2E) ? "R5" : "R10",
          "dn_secure", 64'(sec_o), 64'(exp_sec));
    end
    chk((off_o == req_addr[11:0]) && (sz_o == req_size) && (wr_o == req_write) &&
        (wd_o == req_wdata) && (us_o == req_user), "R11", "forwarded fields",
        {off_o, sz_o, wr_o, us_o}, {req_addr[11:0], req_size, req_write, req_user});
  endtask

  task automatic check_rsp(input int t, input logic rv, input logic [DW-1:0] rd,
                           input logic rf, input logic [19:0] a, input bit wr,
                           input bit us, input logic [3:0] fm, input bit lite);
    logic [DW-1:0] exp_rd;
    logic exp_rf;
    string tg;
    if (t < 0) begin
      exp_rd = '0; exp_rf = us; tg = "R8";
    end else begin
      exp_rd = wr ? '0 : slv_word(t, a[11:0]); exp_rf = fm[t]; tg = "R10";
    end
    chk(rv == 1'b1, "R2", lite ? "lite rsp_valid" : "rsp_valid", 64'(rv), 64'd1);
    chk(rd == exp_rd, tg, lite ? "lite rsp_rdata" : "rsp_rdata", 64'(rd), 64'(exp_rd));
    chk(rf == exp_rf, tg, lite ? "lite rsp_fault" : "rsp_fault", 64'(rf), 64'(exp_rf));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] los [7] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h0EC, 12'h0F0, 12'hFFC};
    int n = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; req_user = 1'b0; req_secure = 1'b0; fmask = '0;
    repeat (3) @(negedge clk);
    chk(!a_rv && !a_rf && a_rd == '0, "R1", "reset outputs", {a_rv, a_rf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_rv && !a_rf && a_rd == '0 && !b_rv, "R1", "after reset", {a_rv, a_rf}, 64'd0);
    chk(a_sel == 4'b0 && b_sel == 4'b0, "R9", "idle sel", 64'(a_sel), 64'd0);

    for (int pg = 0; pg < 256; pg++) begin
      for (int li = 0; li < 7; li++) begin
        for (int at = 0; at < 8; at++) begin
          int ta, tb;
          logic [19:0] a;
          bit wr, us;
          logic [3:0] fm;
          req_valid  = 1'b1;
          req_addr   = {8'(pg), los[li]};
          req_secure = at[0];
          req_user   = at[1];
          req_write  = at[2];
          req_size   = 2'(n);
          req_wdata  = 32'h5A00_0000 | 32'(n);
          fmask      = 4'(pg ^ (n >> 2));
          n++;
          #1;
          ta = exp_tgt(req_addr, req_secure, 1'b1, 1'b1);
          tb = exp_tgt(req_addr, req_secure, 1'b0, 1'b0);
          check_sel(1'b0, ta, a_sel, a_secure, a_off, a_size, a_write, a_wdata, a_user);
          check_sel(1'b1, tb, b_sel, b_secure, b_off, b_size, b_write, b_wdata, b_user);
          a = req_addr; wr = req_write; us = req_user; fm = fmask;
          @(negedge clk);
          check_rsp(ta, a_rv, a_rd, a_rf, a, wr, us, fm, 1'b0);
          check_rsp(tb, b_rv, b_rd, b_rf, a, wr, us, fm, 1'b1);
        end
      end
    end

    req_valid = 1'b0;
    #1;
    chk(a_sel == 4'b0 && b_sel == 4'b0, "R9", "sel after idle", 64'(a_sel), 64'd0);
    @(negedge clk);
    chk(!a_rv && !b_rv, "R2", "rsp_valid after idle", 64'(a_rv), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule